// File: doc/BRIEF.md
# Two-Channel Overflow Interrupt Timer

This peripheral holds two identical timer channels behind a single-cycle register bus. Each channel has a 32-bit up-counter that starts from a programmable start value, advances at a rate set by a prescale divider, and raises a sticky pending flag when it passes from all-ones back to zero. Software clears the flag by writing a one to it. Each channel drives one level-sensitive interrupt line.

Software gets a timeout of N ticks by holding the channel in its reset state, loading the start value with all-ones minus N, and then setting the start bit. The reset bit also serves as pause-and-reload: while it is set, the counter follows the start value and the prescaler is held at zero. Channel 1 repeats the register layout of channel 0 at an offset of 0x40.

Top module: `ovft_top`

## Requirements
- R1: After reset every register of both channels reads zero, and both interrupt outputs are low.
- R2: Within a channel window the registers sit at these offsets: pending status at 0x00 (bit 0), live count at 0x04 (read-only), control at 0x10 (bit 0 reset, bit 1 start), configuration at 0x20 (bit 0 enable, bit 1 interrupt enable), divider at 0x24 and start value at 0x28 (both full 32 bits). Each writable field reads back what was written.
- R3: While control reset is 1, each clock loads the counter with the current start value, so a start value written during reset is picked up one clock later. The prescaler is cleared.
- R4: The counter advances only when start is 1, reset is 0 and enable is 1. In every other case it holds its value.
- R5: With divider D the counter advances once every D+1 clocks of running, counted from the clock on which running begins. D=0 gives one step per clock.
- R6: A step from 0xFFFFFFFF wraps the counter to zero, sets that channel's pending flag, and counting continues.
- R7: A status write with bit 0 set clears the pending flag, and a status write with bit 0 clear has no effect. When an overflow and a clearing write land on the same clock, the flag stays set.
- R8: A channel's interrupt output is high exactly when its pending flag is set and its interrupt enable is 1. The flag itself stays visible in status while the interrupt enable is 0.
- R9: Channel 1 uses the same layout at base 0x40. It runs, interrupts and clears independently of channel 0.
- R10: Unmapped offsets and window indices of 2 and above read zero. Writes to the count register or to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one register write per clock |
| bus_rd | input | 1 | Read strobe, gates bus_rdata |
| bus_addr | input | ADDR_W (8) | Byte address; bits 7:6 pick the channel, bits 5:0 the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when not reading |
| irq | output | NUM_CH (2) | Per-channel level interrupt |

## Verification
The overflow that sets the pending flag and a status write that clears it can fall on the same clock. The bench provokes this by loading the start value with 0xFFFFFFFE, starting the channel, and timing the clearing write onto the second counting edge. The flag must survive, so the interrupt stays high afterwards. A behavioural reference model updated on every clock compares both interrupt lines throughout the run, including this collision.

// File: rtl/ovft_pkg.sv
`timescale 1ns/1ps
package ovft_pkg;
    localparam int CNT_W = 32;
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_STAT = 6'h00;
    localparam logic [OFF_W-1:0] OFF_VAL  = 6'h04;
    localparam logic [OFF_W-1:0] OFF_CTRL = 6'h10;
    localparam logic [OFF_W-1:0] OFF_CFG  = 6'h20;
    localparam logic [OFF_W-1:0] OFF_DIV  = 6'h24;
    localparam logic [OFF_W-1:0] OFF_INIT = 6'h28;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STAT, SEL_VAL, SEL_CTRL, SEL_CFG, SEL_DIV, SEL_INIT
    } reg_sel_e;

    typedef struct packed {
        logic             hold;
        logic             go;
        logic             en;
        logic             ie;
        logic             pend;
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pre;
    } chan_st_t;
endpackage

// File: rtl/ovft_decode.sv
`timescale 1ns/1ps
module ovft_decode
    import ovft_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] hit,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;

    assign idx = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];

    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            hit[k] = (idx == IDX_W'(k));
        end
    end

    always_comb begin
        case (off)
            OFF_STAT: sel = SEL_STAT;
            OFF_VAL:  sel = SEL_VAL;
            OFF_CTRL: sel = SEL_CTRL;
            OFF_CFG:  sel = SEL_CFG;
            OFF_DIV:  sel = SEL_DIV;
            OFF_INIT: sel = SEL_INIT;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/ovft_prescale.sv
`timescale 1ns/1ps
module ovft_prescale #(
    parameter int W = 32
) (
    input  logic [W-1:0] pre_q,
    input  logic [W-1:0] div_q,
    input  logic         clear,
    input  logic         run,
    output logic [W-1:0] pre_d,
    output logic         tick
);
    always_comb begin
        tick  = 1'b0;
        pre_d = pre_q;
        if (clear) begin
            pre_d = '0;
        end else if (run) begin
            if (pre_q == div_q) begin
                tick  = 1'b1;
                pre_d = '0;
            end else begin
                pre_d = pre_q + W'(1);
            end
        end
    end
endmodule

// File: rtl/ovft_channel.sv
`timescale 1ns/1ps
module ovft_channel
    import ovft_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rd_val,
    output logic             irq,
    output logic [CNT_W-1:0] mon_cnt,
    output logic [CNT_W-1:0] mon_init,
    output logic             mon_hold,
    output logic             mon_run,
    output logic             mon_pend,
    output logic             mon_ie
);
    chan_st_t         st_q, st_d;
    logic             run_q;
    logic             tick;
    logic             wrap_d;
    logic             clr_d;
    logic [CNT_W-1:0] pre_d;

    assign run_q = st_q.go & ~st_q.hold & st_q.en;

    ovft_prescale #(.W(CNT_W)) u_pre (
        .pre_q (st_q.pre),
        .div_q (st_q.div),
        .clear (st_q.hold),
        .run   (run_q),
        .pre_d (pre_d),
        .tick  (tick)
    );

    always_comb begin
        st_d   = st_q;
        wrap_d = 1'b0;
        clr_d  = 1'b0;
        st_d.pre = pre_d;

        if (st_q.hold) begin
            st_d.cnt = st_q.init;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            wrap_d   = &st_q.cnt;
        end

        if (wr_en) begin
            case (sel)
                SEL_STAT: clr_d = wdata[0];
                SEL_CTRL: begin
                    st_d.hold = wdata[0];
                    st_d.go   = wdata[1];
                end
                SEL_CFG: begin
                    st_d.en = wdata[0];
                    st_d.ie = wdata[1];
                end
                SEL_DIV:  st_d.div  = wdata;
                SEL_INIT: st_d.init = wdata;
                default: ;
            endcase
        end

        if (wrap_d) begin
            st_d.pend = 1'b1;
        end else if (clr_d) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_STAT: rd_val = CNT_W'(st_q.pend);
            SEL_VAL:  rd_val = st_q.cnt;
            SEL_CTRL: rd_val = CNT_W'({st_q.go, st_q.hold});
            SEL_CFG:  rd_val = CNT_W'({st_q.ie, st_q.en});
            SEL_DIV:  rd_val = st_q.div;
            SEL_INIT: rd_val = st_q.init;
            default:  rd_val = '0;
        endcase
    end

    assign irq      = st_q.pend & st_q.ie;
    assign mon_cnt  = st_q.cnt;
    assign mon_init = st_q.init;
    assign mon_hold = st_q.hold;
    assign mon_run  = run_q;
    assign mon_pend = st_q.pend;
    assign mon_ie   = st_q.ie;
endmodule

// File: rtl/ovft_top.sv
`timescale 1ns/1ps
module ovft_top
    import ovft_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0]            hit;
    reg_sel_e                     sel;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_rd;
    logic [NUM_CH-1:0][CNT_W-1:0] mon_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] mon_init;
    logic [NUM_CH-1:0]            mon_hold;
    logic [NUM_CH-1:0]            mon_run;
    logic [NUM_CH-1:0]            mon_pend;
    logic [NUM_CH-1:0]            mon_ie;

    ovft_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ovft_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr & hit[g]),
            .sel      (sel),
            .wdata    (bus_wdata),
            .rd_val   (ch_rd[g]),
            .irq      (irq[g]),
            .mon_cnt  (mon_cnt[g]),
            .mon_init (mon_init[g]),
            .mon_hold (mon_hold[g]),
            .mon_run  (mon_run[g]),
            .mon_pend (mon_pend[g]),
            .mon_ie   (mon_ie[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (hit[k]) begin
                    bus_rdata = bus_rdata | ch_rd[k];
                end
            end
        end
    end
endmodule

// File: rtl/ovft_checker.sv
`timescale 1ns/1ps
module ovft_checker
    import ovft_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CH-1:0]           irq,
    input logic [NUM_CH-1:0][CNT_W-1:0] mon_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] mon_init,
    input logic [NUM_CH-1:0]           mon_hold,
    input logic [NUM_CH-1:0]           mon_run,
    input logic [NUM_CH-1:0]           mon_pend,
    input logic [NUM_CH-1:0]           mon_ie
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        a_r3_reload_from_init: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mon_hold[g]) |-> mon_cnt[g] == $past(mon_init[g]))
            else $error("R3 counter did not follow start value");

        a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mon_hold[g]) && !$past(mon_run[g])) |-> $stable(mon_cnt[g]))
            else $error("R4 counter moved while stopped");

        a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mon_hold[g]) && mon_cnt[g] != $past(mon_cnt[g]))
                |-> mon_cnt[g] == $past(mon_cnt[g]) + CNT_W'(1))
            else $error("R5 counter jumped by more than one");

        a_r6_wrap_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mon_hold[g]) && $past(mon_cnt[g]) == ALL_ONES && mon_cnt[g] == '0)
                |-> mon_pend[g])
            else $error("R6 wrap without pending");

        a_r7_pending_rises_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mon_pend[g]) |-> mon_cnt[g] == '0)
            else $error("R7 pending set without wrap");

        a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            !mon_ie[g] |-> !irq[g])
            else $error("R8 interrupt while disabled");
    end
endmodule

bind ovft_top ovft_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .mon_cnt  (mon_cnt),
    .mon_init (mon_init),
    .mon_hold (mon_hold),
    .mon_run  (mon_run),
    .mon_pend (mon_pend),
    .mon_ie   (mon_ie)
);

// File: tb/tb_ovft_top.sv
`timescale 1ns/1ps
module tb_ovft_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ovft_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    bit [31:0] m_div [2];
    bit [31:0] m_init[2];
    bit [31:0] m_cnt [2];
    bit [31:0] m_pre [2];
    bit        m_rst [2];
    bit        m_go  [2];
    bit        m_en  [2];
    bit        m_ie  [2];
    bit        m_pend[2];

    always @(posedge clk) begin
        bit wrapped;
        bit clr;
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_div[k] = 0; m_init[k] = 0; m_cnt[k] = 0; m_pre[k] = 0;
                m_rst[k] = 0; m_go[k] = 0; m_en[k] = 0; m_ie[k] = 0; m_pend[k] = 0;
            end else begin
                wrapped = 0;
                clr = 0;
                if (m_rst[k]) begin
                    m_cnt[k] = m_init[k];
                    m_pre[k] = 0;
                end else if (m_go[k] && m_en[k]) begin
                    if (m_pre[k] == m_div[k]) begin
                        m_pre[k] = 0;
                        if (m_cnt[k] == 32'hFFFF_FFFF) wrapped = 1;
                        m_cnt[k] = m_cnt[k] + 1;
                    end else begin
                        m_pre[k] = m_pre[k] + 1;
                    end
                end
                if (bus_wr && int'(bus_addr[7:6]) == k) begin
                    case (bus_addr[5:0])
                        6'h00: clr = bus_wdata[0];
                        6'h10: begin m_rst[k] = bus_wdata[0]; m_go[k] = bus_wdata[1]; end
                        6'h20: begin m_en[k] = bus_wdata[0]; m_ie[k] = bus_wdata[1]; end
                        6'h24: m_div[k] = bus_wdata;
                        6'h28: m_init[k] = bus_wdata;
                        default: ;
                    endcase
                end
                if (wrapped) m_pend[k] = 1;
                else if (clr) m_pend[k] = 0;
            end
        end
    end

    // every-clock comparison of interrupt lines against the model (R8)
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            for (int k = 0; k < 2; k++) begin
                n_chk++;
                if (irq[k] !== (m_pend[k] & m_ie[k])) begin
                    n_err++;
                    $display("FAIL R8 model irq[%0d] actual=%0b expected=%0b at %0t",
                             k, irq[k], m_pend[k] & m_ie[k], $time);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] hold_v;
        logic [7:0]  offs[6];
        offs = '{8'h00, 8'h04, 8'h10, 8'h20, 8'h24, 8'h28};

        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: everything zero after reset
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 6; i++) begin
                rd(offs[i] + 8'(c * 64), v);
                chk("R1 reset register", v, 0);
            end
        end
        chk("R1 irq after reset", 32'(irq), 0);

        // R2: readback of writable fields
        wr(8'h20, 32'h3);        rd(8'h20, v); chk("R2 cfg readback", v, 32'h3);
        wr(8'h24, 32'h5);        rd(8'h24, v); chk("R2 div readback", v, 32'h5);
        wr(8'h28, 32'hA5A5_1234); rd(8'h28, v); chk("R2 init readback", v, 32'hA5A5_1234);
        wr(8'h10, 32'h1);        rd(8'h10, v); chk("R2 ctrl readback", v, 32'h1);
        wr(8'h24, 32'h0);
        wr(8'h20, 32'h0);

        // R3: reset loads start value and tracks changes to it
        wr(8'h28, 32'h1234);
        step(1);
        rd(8'h04, v); chk("R3 load on reset", v, 32'h1234);
        wr(8'h28, 32'h55);
        step(1);
        rd(8'h04, v); chk("R3 tracks new start value", v, 32'h55);

        // R4: start without enable holds, then enable counts
        wr(8'h10, 32'h2);
        step(10);
        rd(8'h04, v); chk("R4 hold without enable", v, 32'h55);
        wr(8'h20, 32'h1);
        step(4);
        rd(8'h04, v); chk("R4 counts once enabled, div 0", v, 32'h59);

        // R5: divider 3 gives one step per 4 clocks
        wr(8'h10, 32'h1);
        wr(8'h24, 32'h3);
        wr(8'h28, 32'd100);
        wr(8'h10, 32'h2);
        step(7);
        rd(8'h04, v); chk("R5 after 7 clocks", v, 32'd101);
        step(1);
        rd(8'h04, v); chk("R5 after 8 clocks", v, 32'd102);

        // R6: overflow wraps and sets pending
        wr(8'h10, 32'h1);
        wr(8'h24, 32'h0);
        wr(8'h20, 32'h3);
        wr(8'h28, 32'hFFFF_FFFD);
        wr(8'h10, 32'h2);
        step(2);
        rd(8'h04, v); chk("R6 at all-ones", v, 32'hFFFF_FFFF);
        chk("R6 no irq before wrap", 32'(irq[0]), 0);
        step(1);
        rd(8'h04, v); chk("R6 wrapped to zero", v, 0);
        rd(8'h00, v); chk("R6 pending set", v, 1);
        chk("R8 irq on pending", 32'(irq[0]), 1);
        step(2);
        rd(8'h04, v); chk("R6 keeps counting", v, 2);

        // R7: clear by writing one; writing zero ignored
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R7 zero write ignored", v, 1);
        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R7 cleared", v, 0);
        chk("R7 irq low after clear", 32'(irq[0]), 0);

        // R7: overflow and clear on the same clock, set wins
        wr(8'h10, 32'h1);
        wr(8'h28, 32'hFFFF_FFFE);
        wr(8'h10, 32'h2);
        step(1);
        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R7 set beats same-cycle clear", v, 1);
        chk("R7 irq after collision", 32'(irq[0]), 1);

        // R8: interrupt enable gates output only
        wr(8'h20, 32'h1);
        chk("R8 irq masked", 32'(irq[0]), 0);
        rd(8'h00, v); chk("R8 pending still visible", v, 1);
        wr(8'h20, 32'h3);
        chk("R8 irq unmasked", 32'(irq[0]), 1);

        // R9: second channel at 0x40
        rd(8'h68, v); chk("R9 ch1 untouched", v, 0);
        chk("R9 ch1 irq low", 32'(irq[1]), 0);
        wr(8'h60, 32'h3);
        wr(8'h50, 32'h1);
        wr(8'h68, 32'hFFFF_FFFF);
        wr(8'h50, 32'h2);
        step(1);
        rd(8'h44, v); chk("R9 ch1 wrapped", v, 0);
        chk("R9 ch1 irq", 32'(irq[1]), 1);
        rd(8'h28, v); chk("R9 ch0 start value unchanged", v, 32'hFFFF_FFFE);
        wr(8'h40, 32'h1);
        chk("R9 ch1 cleared", 32'(irq[1]), 0);
        chk("R9 ch0 still pending", 32'(irq[0]), 1);

        // R10: unmapped reads, ignored writes
        rd(8'h08, v); chk("R10 hole reads zero", v, 0);
        rd(8'h2C, v); chk("R10 hole reads zero", v, 0);
        rd(8'h80, v); chk("R10 window 2 reads zero", v, 0);
        rd(8'hE8, v); chk("R10 window 3 reads zero", v, 0);
        wr(8'h10, 32'h0);
        rd(8'h04, hold_v);
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h04, v); chk("R10 count write ignored", v, hold_v);
        wr(8'hA8, 32'h77);
        rd(8'h28, v); chk("R10 ch0 start after stray write", v, 32'hFFFF_FFFE);
        rd(8'h68, v); chk("R10 ch1 start after stray write", v, 32'hFFFF_FFFF);

        step(2);
        done = 1'b1;
        summary();
    end
endmodule